// File: doc/BRIEF.md
# Multiplexed LCD Row Scan and Blink Timer

This block turns a master clock of roughly 80 kHz into the timing that a dot-matrix LCD driver needs. It steps through the common rows one at a time. It issues a strobe at the start of each row so that the segment data for that row can be latched. It reverses the drive polarity after every complete frame, which keeps the average voltage across the panel at zero. It also produces a slow square wave that blinking display elements follow.

A mode input selects one of two scans. The first is a 9-row scan for a single text line with an indicator row and a cursor row. The second is a 17-row scan for two text lines, each with a cursor row, plus one indicator row. Each frame takes a whole number of master clocks, and that number depends on the mode.

The analog bias voltages are outside this block. Each common output and each segment output is given as a 3-bit level code instead, where code 0 is the top supply level and code 5 is the bottom level. A display-enable input forces every code to the top supply level. The row timing and blink timing keep running while the display is off.

Top module: `lcdscan_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `row_idx` is 0, `latch_stb` is 1, `frame_pol` is 0 and `blink_ph` is 0.
- R2: When `duty_9row`=0 (17-row mode), each row lasts 64 clocks and `row_idx` counts 0..16, so a frame lasts 1088 clocks.
- R3: When `duty_9row`=1 (9-row mode), each row lasts 128 clocks and `row_idx` counts 0..8, so a frame lasts 1152 clocks.
- R4: `latch_stb` is 1 in exactly the first clock of every row and 0 in all other clocks.
- R5: `frame_pol` inverts in the first clock of every new frame and holds its value for the rest of the frame.
- R6: The mode is sampled only during reset and at the end of the last row of a frame. A change at any other time takes effect at the next frame start.
- R7: `blink_ph` is 0 for the first 40960 clocks after reset. After that it inverts every 40960 clocks, giving a full period of 5 x 2^14 = 81920 clocks.
- R8: Common c uses bits `com_lvl[3c+2:3c]`. With the display on, the common whose index equals `row_idx` gets code 5 when `frame_pol`=0 and code 0 when `frame_pol`=1. Every other common gets code 1 when `frame_pol`=0 and code 4 when `frame_pol`=1.
- R9: In 9-row mode, commons 9 to 16 are never selected and stay at the non-select code, 1 or 4.
- R10: Segment i uses bits `seg_lvl[3i+2:3i]`. With the display on, a segment whose `seg_on[i]`=1 gets code 0 when `frame_pol`=0 and code 5 when `frame_pol`=1. A segment whose `seg_on[i]`=0 gets code 2 when `frame_pol`=0 and code 3 when `frame_pol`=1.
- R11: While `disp_en`=0, every common and segment code is 0 (top supply level). The row, polarity and blink timing continue unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, about 80 kHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_9row | input | 1 | 1 selects 9-row scanning, 0 selects 17-row scanning |
| disp_en | input | 1 | 1 drives the panel, 0 forces every output to the top level |
| seg_on | input | 80 | Lit or unlit state of each segment for the current row |
| row_idx | output | 5 | Index of the common row being driven |
| frame_pol | output | 1 | Drive polarity of the current frame |
| latch_stb | output | 1 | High in the first clock of each row |
| blink_ph | output | 1 | 0 while blinking elements are shown, 1 while they are altered |
| com_lvl | output | 51 | 3-bit level code for each of the 17 commons |
| seg_lvl | output | 240 | 3-bit level code for each of the 80 segments |

## Verification
The assertions assume that `duty_9row` is stable while reset is asserted, since the mode is captured there. They make no assumption about when it changes afterwards. They also assume that reset is held for at least one clock edge. The stimulus releases reset and drives every input at the falling clock edge. It changes the mode in the middle of a frame, in both directions, and during a later reset, so the deferred take-over at the frame boundary is exercised. The display enable and the segment pattern are changed freely at any cycle, because the level outputs follow them without any timing constraint.

// File: rtl/lcdscan_pkg.sv
package lcdscan_pkg;

   localparam int LVL_W   = 3;
   localparam int LVL_MAX = 5;

   localparam logic [LVL_W-1:0] LV_TOP     = 3'd0;
   localparam logic [LVL_W-1:0] LV_COM_SEL = 3'd5;
   localparam logic [LVL_W-1:0] LV_COM_NS  = 3'd1;
   localparam logic [LVL_W-1:0] LV_SEG_ON  = 3'd0;
   localparam logic [LVL_W-1:0] LV_SEG_OFF = 3'd2;

   function automatic logic [LVL_W-1:0] lvl_flip(input logic [LVL_W-1:0] code,
                                                  input logic             pol);
      return pol ? (LVL_W'(LVL_MAX) - code) : code;
   endfunction

endpackage

// File: rtl/lcdscan_rowtimer.sv
module lcdscan_rowtimer #(
   parameter int ROWS_A   = 9,
   parameter int ROWS_B   = 17,
   parameter int ROWCLK_A = 128,
   parameter int ROWCLK_B = 64,
   localparam int ROW_W   = $clog2(ROWS_B),
   localparam int TICK_W  = $clog2((ROWCLK_A > ROWCLK_B) ? ROWCLK_A : ROWCLK_B)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_a_in,
   output logic             mode_a,
   output logic [ROW_W-1:0] row_idx,
   output logic             frame_pol,
   output logic             latch_stb
);

   localparam logic [TICK_W-1:0] TICK_END_A = TICK_W'(ROWCLK_A - 1);
   localparam logic [TICK_W-1:0] TICK_END_B = TICK_W'(ROWCLK_B - 1);
   localparam logic [ROW_W-1:0]  ROW_END_A  = ROW_W'(ROWS_A - 1);
   localparam logic [ROW_W-1:0]  ROW_END_B  = ROW_W'(ROWS_B - 1);

   if (ROWS_A > ROWS_B) begin : g_bad_rows
      $error("lcdscan_rowtimer: ROWS_A must not exceed ROWS_B");
   end
   if (ROWCLK_A < 2 || ROWCLK_B < 2) begin : g_bad_rowclk
      $error("lcdscan_rowtimer: a row must last at least two clocks");
   end

   logic [TICK_W-1:0] tick_q;
   logic              tick_end;
   logic              row_end;

   assign tick_end  = (tick_q  == (mode_a ? TICK_END_A : TICK_END_B));
   assign row_end   = (row_idx == (mode_a ? ROW_END_A  : ROW_END_B));
   assign latch_stb = (tick_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q    <= '0;
         row_idx   <= '0;
         frame_pol <= 1'b0;
         mode_a    <= mode_a_in;
      end else if (tick_end) begin
         tick_q <= '0;
         if (row_end) begin
            row_idx   <= '0;
            frame_pol <= ~frame_pol;
            mode_a    <= mode_a_in;
         end else begin
            row_idx <= row_idx + 1'b1;
         end
      end else begin
         tick_q <= tick_q + 1'b1;
      end
   end

   // R2 R3: the row index never leaves the range of the active mode
   a_r2_row_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      row_idx <= (mode_a ? ROW_END_A : ROW_END_B));

   // R4: a new row always opens with the strobe
   a_r4_stb_on_row_change: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(row_idx) |-> latch_stb);

   // R5: polarity moves only at the first clock of row 0
   a_r5_pol_at_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(frame_pol) |-> (latch_stb && row_idx == '0));

   // R6: the mode is taken over only at a frame start
   a_r6_mode_at_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mode_a) |-> (latch_stb && row_idx == '0 && !$stable(frame_pol)));

endmodule

// File: rtl/lcdscan_blink.sv
module lcdscan_blink #(
   parameter int PRESCALE = 5,
   parameter int LOG2_MUL = 14,
   localparam int HALF    = PRESCALE * (2 ** (LOG2_MUL - 1)),
   localparam int CNT_W   = $clog2(HALF)
) (
   input  logic clk,
   input  logic rst_n,
   output logic blink_ph
);

   if (PRESCALE < 1 || LOG2_MUL < 2) begin : g_bad_period
      $error("lcdscan_blink: blink period too short");
   end

   localparam logic [CNT_W-1:0] CNT_END = CNT_W'(HALF - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         blink_ph <= 1'b0;
      end else if (cnt_q == CNT_END) begin
         cnt_q    <= '0;
         blink_ph <= ~blink_ph;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R7: the phase changes only when a half period has just elapsed
   a_r7_phase_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(blink_ph) |-> (cnt_q == '0));

endmodule

// File: rtl/lcdscan_drive.sv
module lcdscan_drive
   import lcdscan_pkg::*;
#(
   parameter int NCOM   = 17,
   parameter int NSEG   = 80,
   parameter int ROWS_A = 9,
   localparam int ROW_W = $clog2(NCOM)
) (
   input  logic                  disp_en,
   input  logic                  frame_pol,
   input  logic                  mode_a,
   input  logic [ROW_W-1:0]      row_idx,
   input  logic [NSEG-1:0]       seg_on,
   output logic [NCOM*LVL_W-1:0] com_lvl,
   output logic [NSEG*LVL_W-1:0] seg_lvl
);

   if (ROWS_A > NCOM) begin : g_bad_com
      $error("lcdscan_drive: more rows scanned than commons present");
   end

   for (genvar c = 0; c < NCOM; c++) begin : g_com
      logic             active;
      logic [LVL_W-1:0] base;
      if (c < ROWS_A) begin : g_always
         assign active = 1'b1;
      end else begin : g_wide_only
         assign active = ~mode_a;
      end
      assign base = (active && row_idx == ROW_W'(c)) ? LV_COM_SEL : LV_COM_NS;
      assign com_lvl[c*LVL_W +: LVL_W] = disp_en ? lvl_flip(base, frame_pol) : LV_TOP;
   end

   for (genvar s = 0; s < NSEG; s++) begin : g_seg
      logic [LVL_W-1:0] base;
      assign base = seg_on[s] ? LV_SEG_ON : LV_SEG_OFF;
      assign seg_lvl[s*LVL_W +: LVL_W] = disp_en ? lvl_flip(base, frame_pol) : LV_TOP;
   end

endmodule

// File: rtl/lcdscan_top.sv
module lcdscan_top
   import lcdscan_pkg::*;
#(
   parameter int NCOM     = 17,
   parameter int NSEG     = 80,
   parameter int ROWS_A   = 9,
   parameter int ROWCLK_A = 128,
   parameter int ROWCLK_B = 64,
   parameter int BLINK_PRESCALE = 5,
   parameter int BLINK_LOG2     = 14,
   localparam int ROW_W   = $clog2(NCOM)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  duty_9row,
   input  logic                  disp_en,
   input  logic [NSEG-1:0]       seg_on,
   output logic [ROW_W-1:0]      row_idx,
   output logic                  frame_pol,
   output logic                  latch_stb,
   output logic                  blink_ph,
   output logic [NCOM*LVL_W-1:0] com_lvl,
   output logic [NSEG*LVL_W-1:0] seg_lvl
);

   logic mode_a;

   lcdscan_rowtimer #(
      .ROWS_A(ROWS_A), .ROWS_B(NCOM), .ROWCLK_A(ROWCLK_A), .ROWCLK_B(ROWCLK_B)
   ) u_rows (
      .clk(clk), .rst_n(rst_n), .mode_a_in(duty_9row), .mode_a(mode_a),
      .row_idx(row_idx), .frame_pol(frame_pol), .latch_stb(latch_stb)
   );

   lcdscan_blink #(
      .PRESCALE(BLINK_PRESCALE), .LOG2_MUL(BLINK_LOG2)
   ) u_blink (
      .clk(clk), .rst_n(rst_n), .blink_ph(blink_ph)
   );

   lcdscan_drive #(
      .NCOM(NCOM), .NSEG(NSEG), .ROWS_A(ROWS_A)
   ) u_drive (
      .disp_en(disp_en), .frame_pol(frame_pol), .mode_a(mode_a),
      .row_idx(row_idx), .seg_on(seg_on), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
   );

   // checker-side view of which commons sit at the select level
   logic [NCOM-1:0] at_sel;
   for (genvar c = 0; c < NCOM; c++) begin : g_chk
      assign at_sel[c] = (com_lvl[c*LVL_W +: LVL_W] == lvl_flip(LV_COM_SEL, frame_pol));
      if (c >= ROWS_A) begin : g_idle
         // R9: upper commons stay unselected in the short scan
         a_r9_idle_common: assert property (@(posedge clk) disable iff (!rst_n)
            (disp_en && mode_a) |-> !at_sel[c]);
      end
   end

   // R8: exactly one common is driven to the select level while the panel is on
   a_r8_single_select: assert property (@(posedge clk) disable iff (!rst_n)
      disp_en |-> ($countones(at_sel) == 1));

   // R11: a dark panel shows no selected common
   a_r11_dark_no_select: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_en |-> (com_lvl == '0 && seg_lvl == '0));

endmodule

// File: tb/lcdscan_top_tb_top.sv
`timescale 1ns/1ps
module lcdscan_top_tb_top;

   localparam int NCOM = 17;
   localparam int NSEG = 80;
   localparam int HALF_BLINK = 40960;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                duty_9row = 1'b0;
   logic                disp_en = 1'b1;
   logic [NSEG-1:0]     seg_on = '0;
   logic [4:0]          row_idx;
   logic                frame_pol;
   logic                latch_stb;
   logic                blink_ph;
   logic [NCOM*3-1:0]   com_lvl;
   logic [NSEG*3-1:0]   seg_lvl;

   always #2.5 clk = ~clk;

   lcdscan_top dut_i (
      .clk(clk), .rst_n(rst_n), .duty_9row(duty_9row), .disp_en(disp_en),
      .seg_on(seg_on), .row_idx(row_idx), .frame_pol(frame_pol),
      .latch_stb(latch_stb), .blink_ph(blink_ph), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
   );

   int  n_chk = 0;
   int  n_fail = 0;
   bit  finished = 0;

   // behavioural reference state
   int  m_pos = 0;
   int  m_cyc = 0;
   bit  m_pol = 0;
   bit  m_duty = 0;
   logic [31:0] lfsr = 32'h1ACE_B00C;

   function automatic int row_len(bit d);
      return d ? 128 : 64;
   endfunction
   function automatic int frame_len(bit d);
      return d ? 1152 : 1088;
   endfunction

   task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic compare();
      int e_row;
      logic [NCOM*3-1:0] e_com;
      logic [NSEG*3-1:0] e_seg;
      e_row = m_pos / row_len(m_duty);
      chk(m_duty ? "R3 R6 row" : "R2 R6 row", 256'(row_idx), 256'(e_row));
      chk("R4 strobe", 256'(latch_stb), 256'((m_pos % row_len(m_duty)) == 0));
      chk("R5 polarity", 256'(frame_pol), 256'(m_pol));
      chk("R7 blink", 256'(blink_ph), 256'((m_cyc / HALF_BLINK) % 2));
      for (int c = 0; c < NCOM; c++) begin
         int code;
         if (m_duty && c >= 9) code = 1;
         else if (c == e_row)  code = 5;
         else                  code = 1;
         if (m_pol) code = 5 - code;
         if (!disp_en) code = 0;
         e_com[c*3 +: 3] = 3'(code);
      end
      for (int s = 0; s < NSEG; s++) begin
         int code;
         code = seg_on[s] ? 0 : 2;
         if (m_pol) code = 5 - code;
         if (!disp_en) code = 0;
         e_seg[s*3 +: 3] = 3'(code);
      end
      if (!disp_en) begin
         chk("R11 commons", 256'(com_lvl), 256'(e_com));
         chk("R11 segments", 256'(seg_lvl), 256'(e_seg));
      end else begin
         chk(m_duty ? "R8 R9 commons" : "R8 commons", 256'(com_lvl), 256'(e_com));
         chk("R10 segments", 256'(seg_lvl), 256'(e_seg));
      end
   endtask

   task automatic step();
      @(posedge clk);
      if (!rst_n) begin
         m_pos = 0; m_cyc = 0; m_pol = 0; m_duty = duty_9row;
      end else begin
         m_cyc++;
         m_pos++;
         if (m_pos == frame_len(m_duty)) begin
            m_pos = 0;
            m_pol = ~m_pol;
            m_duty = duty_9row;
         end
      end
      @(negedge clk);
      compare();
   endtask

   task automatic run(input int n, input bit shuffle);
      for (int i = 0; i < n; i++) begin
         if (shuffle) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            seg_on = {lfsr[15:0], lfsr, ~lfsr};
         end
         step();
      end
   endtask

   task automatic check_reset_state();
      chk("R1 row", 256'(row_idx), 256'(0));
      chk("R1 strobe", 256'(latch_stb), 256'(1));
      chk("R1 polarity", 256'(frame_pol), 256'(0));
      chk("R1 blink", 256'(blink_ph), 256'(0));
   endtask

   initial begin
      run(4, 0);
      check_reset_state();
      rst_n = 1'b1;
      run(2500, 1);              // 17-row scan, R2
      disp_en = 1'b0;
      run(300, 1);               // R11: dark panel, timing keeps going
      disp_en = 1'b1;
      run(37, 1);
      duty_9row = 1'b1;          // R6: change mid-frame
      run(4000, 1);              // R3, R9
      seg_on = '1;
      run(300, 0);
      seg_on = '0;
      run(300, 0);
      duty_9row = 1'b0;
      run(3000, 1);
      duty_9row = 1'b1;          // mode captured during reset
      rst_n = 1'b0;
      run(2, 0);
      check_reset_state();
      rst_n = 1'b1;
      run(2000, 1);
      duty_9row = 1'b0;
      run(83000, 1);             // R7: two blink edges after reset
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #950000;
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule